// File: doc/BRIEF.md
# Network Controller Bring-Up Sequencer

This block brings an external network controller out of a cold reset and leaves it configured. It holds the controller's active-low reset pin low for a timed interval, then releases it. It waits for the controller to report that self-initialization is complete and clears that report. After a settling delay it reads the six factory MAC address bytes and copies them into a local MAC register. It then programs two internal 16-bit MAC-interface registers by indirect access. Last, it hands control to the status-transmit stage by writing the state code `101`.

Every controller register access goes through a byte-wide go/done handshake to a separate transceiver. The work is an ordered list of steps held in a computed step table. A step pointer moves forward only when the current step completes, so each step's completion starts the next. A debug input cuts every timed wait short, which makes bring-up fast on the bench. An asynchronous reset restarts the whole list from its first step.

Top module: `netBringupSeq`

## Requirements
- R1: While `rst` is high: `ctrlRstN` is 0, and `xcvGo`, `macWe` and `stateWe` are all 0.
- R2: An access is a single-cycle `xcvGo` pulse with `xcvAddr`, `xcvWdata` and `xcvRead` (1 = read, 0 = write). `xcvAddr` holds its value until the next pulse. No new pulse is issued until `xcvDone` has returned for the previous one.
- R3: After `rst` falls, `ctrlRstN` stays low for at least `RST_PULSE_CYC` cycles. No access is issued while it is low.
- R4: After the pin is released, the block waits until `ctrlIntN` is low, as seen through a two-flop synchronizer. It then reads status register 0x20. It continues only when the byte read has mask 0x04 set. Otherwise it goes back to waiting and polls again, and issues no other access in the meantime.
- R5: Once the status bit is seen, the next access writes 0x04 to address 0x20. The access after that starts no earlier than `SETTLE_CYC` cycles later.
- R6: While `dbgShort` is high, every timed wait ends at once. The pin is released within 6 cycles of reset, and the gap after the status clear is at most 10 cycles.
- R7: The block reads addresses 0x40 to 0x45 in ascending order. The byte returned by the read of 0x40+k is written to the local MAC register with `macAddr` = k and `macData` equal to that byte.
- R8: Each indirect 16-bit write is four byte writes, in this order:
  - the register index to 0xA0
  - the low data byte to 0xA1
  - the high data byte to 0xA2
  - 0x01 (the write command bit) to 0xA3

  Two such writes follow the MAC copy: index 0x00 with data 0x8000, then index 0x05 with data 0x05EE.
- R9: After the last indirect write, `stateWe` pulses exactly once with `stateD` = 3'b101. After that the block issues no further access.
- R10: An asynchronous reset in the middle of the sequence drives the pin low and stops accesses. After release, the sequence reruns from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| dbgShort | input | 1 | Ends every timed wait at once |
| ctrlRstN | output | 1 | Active-low reset pin of the controller |
| ctrlIntN | input | 1 | Active-low interrupt line of the controller |
| xcvGo | output | 1 | Access start pulse to the transceiver |
| xcvAddr | output | 8 | Controller register address |
| xcvWdata | output | 8 | Write data |
| xcvRead | output | 1 | 1 = read, 0 = write |
| xcvRdata | input | 8 | Byte returned by a read, valid with `xcvDone` |
| xcvDone | input | 1 | Access complete, one cycle |
| macWe | output | 1 | Local MAC register write enable |
| macAddr | output | 4 | Local MAC register byte index |
| macData | output | 8 | Local MAC register byte value |
| stateWe | output | 1 | State register write enable |
| stateD | output | 3 | State register value |

## Verification
The bench builds the block with `RST_PULSE_CYC` = 40 and `SETTLE_CYC` = 25, in place of the defaults of tens of thousands of cycles. With these values a full bring-up finishes in about a hundred cycles. That lets one run cover a normal pass, a shortened debug pass, a pass with a spurious interrupt, and a pass restarted by a reset in the middle. The small lengths also make the pin-low interval and the settle gap short enough to measure from the access trace and compare against their lower bounds. A transceiver model in the bench answers each access after a fixed latency, and clears status bits that are written with a 1.

// File: rtl/bringupPkg.sv
package bringupPkg;

  typedef enum logic [2:0] {
    OP_WAIT, OP_PINREL, OP_INTWAIT, OP_WR, OP_RD, OP_MACCPY, OP_IWR, OP_FINISH
  } stepOp_e;

  typedef struct packed {
    stepOp_e     op;
    logic [7:0]  addr;
    logic [15:0] data;
  } stepEntry_t;

  typedef struct packed {
    logic       issue;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       loadWait;
    logic       waitSel;
    logic       pinRelease;
    logic       macStore;
    logic [3:0] macIdx;
    logic       handoff;
  } ctlStrobe_t;

  localparam int          MAC_BYTES       = 6;
  localparam int          MAC_FIRST_STEP  = 5;
  localparam int          STEP_COUNT      = MAC_FIRST_STEP + MAC_BYTES + 3;
  localparam logic [7:0]  INT_STATUS_ADDR = 8'h20;
  localparam logic [7:0]  INIT_DONE_MASK  = 8'h04;
  localparam logic [7:0]  MAC_ROM_BASE    = 8'h40;
  localparam logic [7:0]  IND_IDX_ADDR    = 8'hA0;
  localparam logic [7:0]  IND_LO_ADDR     = 8'hA1;
  localparam logic [7:0]  IND_HI_ADDR     = 8'hA2;
  localparam logic [7:0]  IND_CMD_ADDR    = 8'hA3;
  localparam logic [7:0]  IND_CMD_WRITE   = 8'h01;
  localparam logic [2:0]  HANDOFF_STATE   = 3'b101;

  // Step table, computed rather than stored.
  function automatic stepEntry_t stepAt(input int idx);
    stepEntry_t e;
    e = '{OP_FINISH, 8'h00, 16'h0000};
    if (idx >= MAC_FIRST_STEP && idx < MAC_FIRST_STEP + MAC_BYTES) begin
      e.op   = OP_MACCPY;
      e.addr = MAC_ROM_BASE + 8'(idx - MAC_FIRST_STEP);
      e.data = 16'(idx - MAC_FIRST_STEP);
    end else begin
      case (idx)
        0: e = '{OP_WAIT, 8'h00, 16'h0000};
        1: e = '{OP_PINREL, 8'h00, 16'h0000};
        2: e = '{OP_INTWAIT, INT_STATUS_ADDR, {8'h00, INIT_DONE_MASK}};
        3: e = '{OP_WR, INT_STATUS_ADDR, {8'h00, INIT_DONE_MASK}};
        4: e = '{OP_WAIT, 8'h00, 16'h0001};
        MAC_FIRST_STEP + MAC_BYTES:     e = '{OP_IWR, 8'h00, 16'h8000};
        MAC_FIRST_STEP + MAC_BYTES + 1: e = '{OP_IWR, 8'h05, 16'h05EE};
        default: e = '{OP_FINISH, 8'h00, 16'h0000};
      endcase
    end
    return e;
  endfunction

  // Byte access number sub of an indirect 16-bit write: {address, data}.
  function automatic logic [15:0] indByte(input stepEntry_t e, input logic [1:0] sub);
    case (sub)
      2'd0:    return {IND_IDX_ADDR, e.addr};
      2'd1:    return {IND_LO_ADDR, e.data[7:0]};
      2'd2:    return {IND_HI_ADDR, e.data[15:8]};
      default: return {IND_CMD_ADDR, IND_CMD_WRITE};
    endcase
  endfunction

endpackage

// File: rtl/bringupCtl.sv
module bringupCtl
  import bringupPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       waitDone,
  input  logic       intSeen,
  input  logic       xcvDone,
  input  logic [7:0] xcvRdata,
  output ctlStrobe_t strobe
);
  localparam int PTR_W = $clog2(STEP_COUNT);

  typedef enum logic [2:0] {C_FETCH, C_WAIT, C_INTW, C_XFER, C_END} ctlState_e;

  ctlState_e  state, stateNext;
  logic [PTR_W-1:0] ptr, ptrNext;
  logic [1:0] sub, subNext;
  stepEntry_t cur;

  assign cur = stepAt(int'(ptr));

  always_comb begin
    strobe    = '0;
    stateNext = state;
    ptrNext   = ptr;
    subNext   = sub;
    case (state)
      C_FETCH: begin
        case (cur.op)
          OP_WAIT: begin
            strobe.loadWait = 1'b1;
            strobe.waitSel  = cur.data[0];
            stateNext       = C_WAIT;
          end
          OP_PINREL: begin
            strobe.pinRelease = 1'b1;
            ptrNext           = ptr + 1'b1;
          end
          OP_INTWAIT: stateNext = C_INTW;
          OP_WR, OP_RD, OP_MACCPY: begin
            strobe.issue = 1'b1;
            strobe.rd    = (cur.op != OP_WR);
            strobe.addr  = cur.addr;
            strobe.wdata = cur.data[7:0];
            stateNext    = C_XFER;
          end
          OP_IWR: begin
            strobe.issue = 1'b1;
            {strobe.addr, strobe.wdata} = indByte(cur, 2'd0);
            subNext      = 2'd0;
            stateNext    = C_XFER;
          end
          default: begin
            strobe.handoff = 1'b1;
            stateNext      = C_END;
          end
        endcase
      end
      C_WAIT: begin
        if (waitDone) begin
          ptrNext   = ptr + 1'b1;
          stateNext = C_FETCH;
        end
      end
      C_INTW: begin
        if (intSeen) begin
          strobe.issue = 1'b1;
          strobe.rd    = 1'b1;
          strobe.addr  = cur.addr;
          stateNext    = C_XFER;
        end
      end
      C_XFER: begin
        if (xcvDone) begin
          case (cur.op)
            OP_INTWAIT: begin
              if ((xcvRdata & cur.data[7:0]) != 8'h00) begin
                ptrNext   = ptr + 1'b1;
                stateNext = C_FETCH;
              end else begin
                stateNext = C_INTW;
              end
            end
            OP_IWR: begin
              if (sub == 2'd3) begin
                ptrNext   = ptr + 1'b1;
                stateNext = C_FETCH;
              end else begin
                subNext      = sub + 2'd1;
                strobe.issue = 1'b1;
                {strobe.addr, strobe.wdata} = indByte(cur, sub + 2'd1);
              end
            end
            OP_MACCPY: begin
              strobe.macStore = 1'b1;
              strobe.macIdx   = cur.data[3:0];
              ptrNext         = ptr + 1'b1;
              stateNext       = C_FETCH;
            end
            default: begin
              ptrNext   = ptr + 1'b1;
              stateNext = C_FETCH;
            end
          endcase
        end
      end
      default: stateNext = C_END;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= C_FETCH;
      ptr   <= '0;
      sub   <= '0;
    end else begin
      state <= stateNext;
      ptr   <= ptrNext;
      sub   <= subNext;
    end
  end

endmodule

// File: rtl/bringupDp.sv
module bringupDp
  import bringupPkg::*;
#(
  parameter int RST_PULSE_CYC = 50000,
  parameter int SETTLE_CYC    = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  input  logic       dbgShort,
  input  logic       ctrlIntN,
  input  logic [7:0] xcvRdata,
  output logic       waitDone,
  output logic       intSeen,
  output logic       ctrlRstN,
  output logic       xcvGo,
  output logic [7:0] xcvAddr,
  output logic [7:0] xcvWdata,
  output logic       xcvRead,
  output logic       macWe,
  output logic [3:0] macAddr,
  output logic [7:0] macData,
  output logic       stateWe,
  output logic [2:0] stateD
);
  localparam int LONGEST = (RST_PULSE_CYC > SETTLE_CYC) ? RST_PULSE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 2);

  logic [CNT_W-1:0] waitCnt;
  logic [1:0]       intSync;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= strobe.waitSel ? CNT_W'(SETTLE_CYC) : CNT_W'(RST_PULSE_CYC);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0) || dbgShort;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) intSync <= 2'b11;
    else     intSync <= {intSync[0], ctrlIntN};
  end

  assign intSeen = ~intSync[1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctrlRstN <= 1'b0;
      xcvGo    <= 1'b0;
      xcvAddr  <= '0;
      xcvWdata <= '0;
      xcvRead  <= 1'b0;
      macWe    <= 1'b0;
      macAddr  <= '0;
      macData  <= '0;
      stateWe  <= 1'b0;
      stateD   <= '0;
    end else begin
      if (strobe.pinRelease) ctrlRstN <= 1'b1;
      xcvGo <= strobe.issue;
      if (strobe.issue) begin
        xcvAddr  <= strobe.addr;
        xcvWdata <= strobe.wdata;
        xcvRead  <= strobe.rd;
      end
      macWe <= strobe.macStore;
      if (strobe.macStore) begin
        macAddr <= strobe.macIdx;
        macData <= xcvRdata;
      end
      stateWe <= strobe.handoff;
      stateD  <= strobe.handoff ? HANDOFF_STATE : 3'b000;
    end
  end

endmodule

// File: rtl/netBringupSeq.sv
module netBringupSeq
  import bringupPkg::*;
#(
  parameter int RST_PULSE_CYC = 50000,
  parameter int SETTLE_CYC    = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dbgShort,
  output logic       ctrlRstN,
  input  logic       ctrlIntN,
  output logic       xcvGo,
  output logic [7:0] xcvAddr,
  output logic [7:0] xcvWdata,
  output logic       xcvRead,
  input  logic [7:0] xcvRdata,
  input  logic       xcvDone,
  output logic       macWe,
  output logic [3:0] macAddr,
  output logic [7:0] macData,
  output logic       stateWe,
  output logic [2:0] stateD
);
  ctlStrobe_t strobe;
  logic       waitDone;
  logic       intSeen;

  bringupCtl ctl (
    .clk(clk), .rst(rst), .waitDone(waitDone), .intSeen(intSeen),
    .xcvDone(xcvDone), .xcvRdata(xcvRdata), .strobe(strobe)
  );

  bringupDp #(.RST_PULSE_CYC(RST_PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dbgShort(dbgShort),
    .ctrlIntN(ctrlIntN), .xcvRdata(xcvRdata), .waitDone(waitDone),
    .intSeen(intSeen), .ctrlRstN(ctrlRstN), .xcvGo(xcvGo),
    .xcvAddr(xcvAddr), .xcvWdata(xcvWdata), .xcvRead(xcvRead),
    .macWe(macWe), .macAddr(macAddr), .macData(macData),
    .stateWe(stateWe), .stateD(stateD)
  );

endmodule

// File: rtl/netBringupSeqChk.sv
module netBringupSeqChk (
  input logic       clk,
  input logic       rst,
  input logic       ctrlRstN,
  input logic       xcvGo,
  input logic [7:0] xcvAddr,
  input logic       macWe,
  input logic [3:0] macAddr,
  input logic       stateWe,
  input logic [2:0] stateD
);
  logic handoffSeen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          handoffSeen <= 1'b0;
    else if (stateWe) handoffSeen <= 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |-> (!ctrlRstN && !xcvGo && !macWe && !stateWe));

  // R2
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    xcvGo |=> !xcvGo);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xcvGo |-> $stable(xcvAddr));

  // R3
  no_access_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrlRstN |-> !xcvGo);

  // R7
  mac_index_chk: assert property (@(posedge clk) disable iff (rst)
    macWe |-> (macAddr < 4'd6));

  // R9
  handoff_value_chk: assert property (@(posedge clk) disable iff (rst)
    stateWe |-> (stateD == 3'b101));

  // R9
  handoff_once_chk: assert property (@(posedge clk) disable iff (rst)
    stateWe |-> !handoffSeen);

  // R9
  quiet_after_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    handoffSeen |-> !xcvGo);

endmodule

bind netBringupSeq netBringupSeqChk chk (
  .clk(clk), .rst(rst), .ctrlRstN(ctrlRstN), .xcvGo(xcvGo),
  .xcvAddr(xcvAddr), .macWe(macWe), .macAddr(macAddr),
  .stateWe(stateWe), .stateD(stateD)
);

// File: tb/netBringupSeq_test.sv
`timescale 1ns/1ps
module netBringupSeq_test;
  localparam int RP = 40;
  localparam int ST = 25;
  localparam int TRACE_LEN = 15;

  // {read flag, address, data} expected from the status clear onward
  localparam logic [16:0] EXP_TRACE [TRACE_LEN] = '{
    {1'b0, 8'h20, 8'h04},
    {1'b1, 8'h40, 8'h02}, {1'b1, 8'h41, 8'h1A}, {1'b1, 8'h42, 8'h2B},
    {1'b1, 8'h43, 8'h3C}, {1'b1, 8'h44, 8'h4D}, {1'b1, 8'h45, 8'h5E},
    {1'b0, 8'hA0, 8'h00}, {1'b0, 8'hA1, 8'h00}, {1'b0, 8'hA2, 8'h80}, {1'b0, 8'hA3, 8'h01},
    {1'b0, 8'hA0, 8'h05}, {1'b0, 8'hA1, 8'hEE}, {1'b0, 8'hA2, 8'h05}, {1'b0, 8'hA3, 8'h01}
  };
  localparam logic [7:0] MAC_SEED [6] = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbgShort = 1'b0;
  logic ctrlRstN, ctrlIntN, xcvGo, xcvRead, macWe, stateWe;
  logic [7:0] xcvAddr, xcvWdata, macData;
  logic [7:0] xcvRdata = 8'h00;
  logic xcvDone = 1'b0;
  logic [3:0] macAddr;
  logic [2:0] stateD;

  always #10 clk = ~clk;

  netBringupSeq #(.RST_PULSE_CYC(RP), .SETTLE_CYC(ST)) uut (
    .clk(clk), .rst(rst), .dbgShort(dbgShort), .ctrlRstN(ctrlRstN),
    .ctrlIntN(ctrlIntN), .xcvGo(xcvGo), .xcvAddr(xcvAddr),
    .xcvWdata(xcvWdata), .xcvRead(xcvRead), .xcvRdata(xcvRdata),
    .xcvDone(xcvDone), .macWe(macWe), .macAddr(macAddr),
    .macData(macData), .stateWe(stateWe), .stateD(stateD)
  );

  int checks = 0;
  int fails = 0;

  logic [7:0] mem [0:255];
  logic       logRd [64];
  logic [7:0] logAddr [64];
  logic [7:0] logData [64];
  int         logCyc [64];
  int         logN = 0;
  logic [7:0] macLog [6];
  int macWrN = 0, stateWrN = 0, goDouble = 0, goOverlap = 0, cyc = 0;
  logic [2:0] lastStateD = 3'b000;
  bit autoInt = 1'b1, intArmed = 1'b0, spuriousHold = 1'b0, intLine = 1'b0;
  bit busy = 1'b0, pRd = 1'b0, goPrev = 1'b0;
  int lat = 0, armCnt = 0;
  int intDelay = 12;
  logic [7:0] pA = 8'h00, pD = 8'h00;

  assign ctrlIntN = ~intLine;

  // Transceiver and controller model, evaluated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        busy = 0; xcvDone = 0; armCnt = 0; intArmed = autoInt;
        logN = 0; macWrN = 0; stateWrN = 0; goPrev = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int k = 0; k < 6; k++) begin mem[8'h40 + k] = MAC_SEED[k]; macLog[k] = 8'h00; end
      end else begin
        if (intArmed && ctrlRstN) begin
          armCnt++;
          if (armCnt == intDelay) begin mem[8'h20] = mem[8'h20] | 8'h04; intArmed = 0; end
        end
        if (xcvDone) xcvDone = 0;
        if (busy) begin
          lat--;
          if (lat == 0) begin
            xcvDone = 1;
            xcvRdata = pRd ? mem[pA] : 8'h00;
            if (!pRd) begin
              if (pA == 8'h20) mem[pA] = mem[pA] & ~pD;
              else mem[pA] = pD;
            end
            busy = 0;
          end
        end
        if (xcvGo) begin
          if (goPrev) goDouble++;
          if (busy) goOverlap++;
          else begin
            busy = 1; lat = 2; pRd = xcvRead; pA = xcvAddr; pD = xcvWdata;
            if (logN < 64) begin
              logRd[logN] = xcvRead; logAddr[logN] = xcvAddr;
              logData[logN] = xcvRead ? mem[xcvAddr] : xcvWdata;
              logCyc[logN] = cyc;
              logN++;
            end
          end
        end
        goPrev = xcvGo;
        if (macWe) begin
          if (macAddr < 4'd6) macLog[macAddr] = macData;
          macWrN++;
        end
        if (stateWe) begin stateWrN++; lastStateD = stateD; end
      end
      intLine = spuriousHold | mem[8'h20][2];
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkTrue(input string tag, input bit ok, input int act, input int bound);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d against bound %0d", tag, act, bound);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measurePinLow(output int n);
    n = 0;
    while (ctrlRstN == 1'b0 && n < 5000) begin
      @(negedge clk);
      if (!ctrlRstN) n++;
    end
  endtask

  task automatic waitHandoff();
    int t = 0;
    while (stateWrN == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
  endtask

  // Compare the recorded access trace against the expected table
  task automatic checkTrace(output int gap);
    int fw = -1;
    bool_loop: for (int i = 0; i < logN; i++) begin
      if (!logRd[i]) begin fw = i; break; end
    end
    gap = 0;
    chkTrue("R4 status read before clear", fw >= 1, fw, 1);
    if (fw < 1) return;
    for (int i = 0; i < fw; i++)
      chkEq("R4 only status polls before clear", {logRd[i], logAddr[i]}, {1'b1, 8'h20});
    chkEq("R9 total accesses", logN, fw + TRACE_LEN);
    for (int i = 0; i < TRACE_LEN; i++) begin
      if (fw + i < 64)
        chkEq((i == 0) ? "R5 status clear" : (i < 7) ? "R7 mac read" : "R8 indirect write",
              {logRd[fw + i], logAddr[fw + i], logData[fw + i]}, EXP_TRACE[i]);
    end
    for (int k = 0; k < 6; k++) chkEq("R7 local mac byte", macLog[k], MAC_SEED[k]);
    chkEq("R7 mac store count", macWrN, 6);
    chkEq("R9 handoff count", stateWrN, 1);
    chkEq("R9 handoff value", lastStateD, 3'b101);
    gap = logCyc[fw + 1] - logCyc[fw];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got %0d expected completion", checks);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int pinLow, gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1 pin low in reset", ctrlRstN, 0);
    chkEq("R1 go idle in reset", xcvGo, 0);
    chkEq("R1 mac write idle", macWe, 0);
    chkEq("R1 state write idle", stateWe, 0);

    // Normal pass: R3, R5, R7, R8, R9
    rst = 1'b0;
    measurePinLow(pinLow);
    chkTrue("R3 pin low length", pinLow >= RP, pinLow, RP);
    waitHandoff();
    checkTrace(gap);
    chkTrue("R5 settle gap", gap >= ST, gap, ST);

    // Debug shortening: R6
    dbgShort = 1'b1;
    doReset();
    measurePinLow(pinLow);
    chkTrue("R6 pin low shortened", pinLow <= 6, pinLow, 6);
    waitHandoff();
    checkTrace(gap);
    chkTrue("R6 settle gap shortened", gap <= 10, gap, 10);
    dbgShort = 1'b0;

    // Spurious interrupt: line low but status bit clear (R4)
    autoInt = 1'b0;
    doReset();
    measurePinLow(pinLow);
    @(posedge clk);
    mem[8'h20] = 8'h01;
    spuriousHold = 1'b1;
    repeat (40) @(negedge clk);
    chkTrue("R4 repeated polling", logN >= 2, logN, 2);
    for (int i = 0; i < logN && i < 64; i++)
      chkEq("R4 no progress without mask bit", {logRd[i], logAddr[i]}, {1'b1, 8'h20});
    chkEq("R4 no handoff yet", stateWrN, 0);
    @(posedge clk);
    mem[8'h20] = mem[8'h20] | 8'h04;
    spuriousHold = 1'b0;
    waitHandoff();
    checkTrace(gap);
    autoInt = 1'b1;

    // Reset in the middle of the MAC copy (R10)
    doReset();
    begin
      int t = 0;
      while (macWrN < 2 && t < 5000) begin @(negedge clk); t++; end
    end
    rst = 1'b1;
    @(negedge clk);
    chkEq("R10 pin low after mid reset", ctrlRstN, 0);
    chkEq("R10 go idle after mid reset", xcvGo, 0);
    chkEq("R10 no handoff", stateWrN, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    measurePinLow(pinLow);
    chkTrue("R10 rerun from pin pulse", pinLow >= RP, pinLow, RP);
    waitHandoff();
    checkTrace(gap);

    // R2 handshake discipline over all runs
    chkEq("R2 go single cycle", goDouble, 0);
    chkEq("R2 no go while busy", goOverlap, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule